// File: doc/BRIEF.md
# Boot and POST Bus Snooper

This block listens, without driving anything, to an ISA-style expansion bus of a board under test. It sees the 20-bit address, the 16-bit data, the active-low memory-read strobe and the active-low I/O-write strobe. It uses them to judge whether the board came up. A hold counter measures the board reset. Capture is armed only when that reset was held long enough and has then been released. The first memory read of the reset vector at 0xFFFF0 starts capture. That read and each later memory read are stored as address/data records, up to a fixed depth.

After the trigger, I/O writes to the POST port 0x80 are decoded and the byte written is kept. On a cold start, the final byte gives the verdict: 0xFF passes and any other value is a fault code. A timeout flags a board that never writes a POST code. A board that writes 0xFF as its very first code while the boot fetches never moved past the vector is flagged for a retest. On a warm restart the POST verdict is suppressed. A test controller reads the records through a combinational indexed port.

Top module: `boot_post_snoop`

## Requirements
- R1: `rec_count` counts stored records and never decreases while the board reset stays released. A new board reset clears it to 0, along with every status output.
- R2: Capture arms only when `bus_rst` was high for at least HOLD_CYC system clocks and has then gone low. Memory reads before a vector fetch are not recorded. A reset that is too short leaves a vector fetch unrecorded.
- R3: Record 0 is the vector fetch (address 0xFFFF0). Each later memory read is stored in order with its address and full 16-bit data, read back at `rd_idx` on `rd_addr`/`rd_data`.
- R4: `boot_bad` goes high when the low byte of the vector-fetch data is not 0xEA, and stays low when it is 0xEA.
- R5: An I/O write whose address bits [15:0] equal 0x0080 updates `post_code` with data bits [7:0]. I/O writes to other ports leave it unchanged.
- R6: On a cold start, `post_pass` is high when the last POST byte is 0xFF. `post_fail` is high when the last byte is anything else. The two are never high together.
- R7: When `cold_start` is low during the board reset (warm restart), `post_pass`, `post_fail` and `no_post` stay low whatever is written to port 0x80.
- R8: When the first POST byte after the trigger is 0xFF and at most one record exists, `retest` goes high and `post_pass` stays low.
- R9: At most N_REC (16) records are stored. Further reads are dropped and `rec_count` holds at N_REC.
- R10: On a cold start, `no_post` goes high when POST_TMO system clocks pass after the trigger with no write to port 0x80. It is low before that.
- R11: Bus inputs pass through two synchronizing flops. Address and data are taken on the trailing (rising) edge of the strobe, so a value that changes while the strobe is low is recorded as its final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| cold_start | input | 1 | 1 = the current board reset is a power-on start, sampled while `bus_rst` is high |
| bus_rst | input | 1 | Board reset seen on the bus, active high, asynchronous |
| bus_addr | input | 20 | Bus address, asynchronous |
| bus_data | input | 16 | Bus data, asynchronous |
| bus_memr_n | input | 1 | Memory-read strobe, active low |
| bus_iow_n | input | 1 | I/O-write strobe, active low |
| rd_idx | input | 4 | Record index for read-out |
| rd_addr | output | 20 | Address of the selected record |
| rd_data | output | 16 | Data of the selected record |
| rec_count | output | 5 | Number of stored records |
| boot_seen | output | 1 | Vector fetch observed |
| boot_bad | output | 1 | Vector fetch lacks the 0xEA opcode byte |
| post_code | output | 8 | Last byte written to port 0x80 |
| post_pass | output | 1 | Cold start passed POST |
| post_fail | output | 1 | Cold start ended with a fault code |
| retest | output | 1 | Board appears not to run; retest |
| no_post | output | 1 | No POST write before the timeout |

## Verification
The bench replays several boot traces:
- A healthy cold boot with stray reads and a stray port write. This separates correct triggering and port decoding from loose matching.
- A boot that ends on a fault code, and a vector fetch lacking 0xEA. These separate the pass, fail and bad-boot verdicts.
- A warm restart, and a stalled board that writes 0xFF at once. These show that the verdict is suppressed or replaced.
- An over-long fetch stream, a silent board, a reset that is too short, and a read whose data changes under the strobe. These exercise the buffer limit, the timeout, the hold check and the trailing-edge sampling.

// File: rtl/boot_post_snoop.sv
module boot_post_snoop #(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int N_REC     = 16,
  parameter int HOLD_CYC  = 16,
  parameter int POST_TMO  = 1 << 24,
  parameter logic [19:0] VEC_ADDR  = 20'hFFFF0,
  parameter logic [15:0] POST_PORT = 16'h0080
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cold_start,
  input  logic                       bus_rst,
  input  logic [AW-1:0]              bus_addr,
  input  logic [DW-1:0]              bus_data,
  input  logic                       bus_memr_n,
  input  logic                       bus_iow_n,
  input  logic [$clog2(N_REC)-1:0]   rd_idx,
  output logic [AW-1:0]              rd_addr,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(N_REC+1)-1:0] rec_count,
  output logic                       boot_seen,
  output logic                       boot_bad,
  output logic [7:0]                 post_code,
  output logic                       post_pass,
  output logic                       post_fail,
  output logic                       retest,
  output logic                       no_post
);
  localparam int CW = $clog2(N_REC + 1);
  localparam int IW = $clog2(N_REC);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int TW = $clog2(POST_TMO + 1);

  logic [1:0]    rst_sy;
  logic [2:0]    memr_sy, iow_sy;
  logic [AW-1:0] addr_s1, addr_s2;
  logic [DW-1:0] data_s1, data_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_sy  <= '0;
      memr_sy <= '1;
      iow_sy  <= '1;
      addr_s1 <= '0; addr_s2 <= '0;
      data_s1 <= '0; data_s2 <= '0;
    end else begin
      rst_sy  <= {rst_sy[0], bus_rst};
      memr_sy <= {memr_sy[1:0], bus_memr_n};
      iow_sy  <= {iow_sy[1:0], bus_iow_n};
      addr_s1 <= bus_addr; addr_s2 <= addr_s1;
      data_s1 <= bus_data; data_s2 <= data_s1;
    end

  wire brst    = rst_sy[1];
  wire rd_evt  = memr_sy[1] & ~memr_sy[2];
  wire wr_evt  = iow_sy[1] & ~iow_sy[2];
  wire vec_hit = addr_s2 == AW'(VEC_ADDR);
  wire port_hit = addr_s2[15:0] == POST_PORT;

  logic [HW-1:0] hold_cnt;
  logic [TW-1:0] tmo_cnt;
  logic          armed, trig, cold_q, post_seen;
  logic [AW-1:0] rec_addr [N_REC];
  logic [DW-1:0] rec_data [N_REC];

  wire first_hit = armed & ~trig & rd_evt & vec_hit;
  wire more_hit  = trig & rd_evt & (rec_count < CW'(N_REC));
  wire cap_en    = ~brst & (first_hit | more_hit);
  wire [IW-1:0] wr_idx = trig ? rec_count[IW-1:0] : '0;
  wire post_wr   = ~brst & trig & wr_evt & port_hit;

  always_ff @(posedge clk)
    if (cap_en) begin
      rec_addr[wr_idx] <= addr_s2;
      rec_data[wr_idx] <= data_s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_cnt <= '0; armed <= 1'b0; trig <= 1'b0; cold_q <= 1'b1;
      rec_count <= '0; boot_bad <= 1'b0; post_seen <= 1'b0;
      post_code <= '0; retest <= 1'b0; tmo_cnt <= '0; no_post <= 1'b0;
    end else if (brst) begin
      if (hold_cnt != HW'(HOLD_CYC)) hold_cnt <= hold_cnt + 1'b1;
      armed <= 1'b0; trig <= 1'b0; cold_q <= cold_start;
      rec_count <= '0; boot_bad <= 1'b0; post_seen <= 1'b0;
      post_code <= '0; retest <= 1'b0; tmo_cnt <= '0; no_post <= 1'b0;
    end else begin
      if (hold_cnt != '0) begin
        hold_cnt <= '0;
        armed    <= hold_cnt == HW'(HOLD_CYC);
      end
      if (first_hit) begin
        trig      <= 1'b1;
        rec_count <= CW'(1);
        boot_bad  <= data_s2[7:0] != 8'hEA;
      end else if (more_hit) begin
        rec_count <= rec_count + 1'b1;
      end
      if (post_wr) begin
        post_code <= data_s2[7:0];
        post_seen <= 1'b1;
        if (!post_seen && data_s2[7:0] == 8'hFF && rec_count <= CW'(1))
          retest <= 1'b1;
      end
      if (trig && cold_q && !post_seen && !post_wr && !no_post) begin
        if (tmo_cnt == TW'(POST_TMO - 1)) no_post <= 1'b1;
        else tmo_cnt <= tmo_cnt + 1'b1;
      end
    end

  assign boot_seen = trig;
  assign post_pass = cold_q & post_seen & (post_code == 8'hFF) & ~retest;
  assign post_fail = cold_q & post_seen & (post_code != 8'hFF);
  assign rd_addr   = rec_addr[rd_idx];
  assign rd_data   = rec_data[rd_idx];
endmodule

module boot_post_snoop_chk #(parameter int N_REC = 16, parameter int CW = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic          brst,
  input logic          cold_q,
  input logic          wr_evt_port,
  input logic [CW-1:0] rec_count,
  input logic [7:0]    post_code,
  input logic          post_pass,
  input logic          post_fail,
  input logic          retest,
  input logic          no_post
);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= CW'(N_REC));
  a_r1_count_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !brst |=> rec_count >= $past(rec_count));
  a_r6_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(post_pass && post_fail));
  a_r7_warm_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !cold_q |-> (!post_pass && !post_fail && !no_post));
  a_r8_retest_not_pass: assert property (@(posedge clk) disable iff (!rst_n)
    retest |-> !post_pass);
  a_r5_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!brst && !wr_evt_port) |=> $stable(post_code));
endmodule

bind boot_post_snoop boot_post_snoop_chk #(.N_REC(N_REC), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .brst(brst), .cold_q(cold_q),
  .wr_evt_port(post_wr), .rec_count(rec_count), .post_code(post_code),
  .post_pass(post_pass), .post_fail(post_fail), .retest(retest),
  .no_post(no_post)
);

// File: tb/test_boot_post_snoop.sv
module test_boot_post_snoop;
  localparam int CLK_P = 10;
  localparam int HOLD  = 8;
  localparam int TMO   = 300;

  logic clk = 0, rst_n = 0;
  logic cold_start = 1, bus_rst = 0, memr_n = 1, iow_n = 1;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic [3:0]  rd_idx = '0;
  logic [19:0] rd_addr;
  logic [15:0] rd_data;
  logic [4:0]  rec_count;
  logic boot_seen, boot_bad, post_pass, post_fail, retest, no_post;
  logic [7:0] post_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  boot_post_snoop #(.HOLD_CYC(HOLD), .POST_TMO(TMO)) i_boot_post_snoop (
    .clk(clk), .rst_n(rst_n), .cold_start(cold_start), .bus_rst(bus_rst),
    .bus_addr(addr), .bus_data(data), .bus_memr_n(memr_n), .bus_iow_n(iow_n),
    .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_data(rd_data),
    .rec_count(rec_count), .boot_seen(boot_seen), .boot_bad(boot_bad),
    .post_code(post_code), .post_pass(post_pass), .post_fail(post_fail),
    .retest(retest), .no_post(no_post));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic board_reset(int len, bit cold);
    @(negedge clk); cold_start = cold; bus_rst = 1;
    idle(len); bus_rst = 0; idle(6);
  endtask

  task automatic mem_rd(logic [19:0] a, logic [15:0] d);
    @(negedge clk); addr = a; data = d; memr_n = 0;
    idle(3); memr_n = 1; idle(6);
  endtask

  task automatic io_wr(logic [19:0] a, logic [15:0] d);
    @(negedge clk); addr = a; data = d; iow_n = 0;
    idle(3); iow_n = 1; idle(6);
  endtask

  task automatic rec_is(string req, int i, logic [19:0] a, logic [15:0] d);
    rd_idx = 4'(i); #1;
    check(req, rd_addr, a);
    check(req, rd_data, d);
  endtask

  task automatic t_reset_state;
    check("R1 count at reset", rec_count, 0);
    check("R6 pass at reset", post_pass, 0);
    check("R6 fail at reset", post_fail, 0);
    check("R10 no_post at reset", no_post, 0);
  endtask

  task automatic t_short_reset;
    board_reset(3, 1);
    mem_rd(20'hFFFF0, 16'h5BEA);
    check("R2 short reset no arm", rec_count, 0);
    check("R2 short reset no trigger", boot_seen, 0);
  endtask

  task automatic t_good_boot;
    board_reset(20, 1);
    mem_rd(20'h00400, 16'h1234);
    check("R2 pre-trigger read ignored", rec_count, 0);
    mem_rd(20'hFFFF0, 16'h5BEA);
    mem_rd(20'hFE05B, 16'h31C0);
    mem_rd(20'hFE05D, 16'h8ED8);
    check("R1 count", rec_count, 3);
    check("R4 good opcode", boot_bad, 0);
    rec_is("R3 rec0", 0, 20'hFFFF0, 16'h5BEA);
    rec_is("R3 rec1", 1, 20'hFE05B, 16'h31C0);
    rec_is("R3 rec2", 2, 20'hFE05D, 16'h8ED8);
    io_wr(20'h00080, 16'h0012);
    check("R5 code latched", post_code, 8'h12);
    check("R6 fail on 12", post_fail, 1);
    io_wr(20'h00081, 16'h0077);
    check("R5 other port ignored", post_code, 8'h12);
    io_wr(20'h00080, 16'h00FF);
    check("R6 pass", post_pass, 1);
    check("R6 no fail", post_fail, 0);
    check("R8 no retest", retest, 0);
    board_reset(20, 1);
    check("R1 cleared by reset", rec_count, 0);
    check("R1 pass cleared", post_pass, 0);
  endtask

  task automatic t_fault_code;
    board_reset(20, 1);
    mem_rd(20'hFFFF0, 16'h5BEA);
    mem_rd(20'hFE05B, 16'h31C0);
    io_wr(20'h00080, 16'h00FF);
    io_wr(20'h00080, 16'h0024);
    check("R6 final fault code", post_code, 8'h24);
    check("R6 fail", post_fail, 1);
    check("R6 pass low", post_pass, 0);
  endtask

  task automatic t_bad_boot;
    board_reset(20, 1);
    mem_rd(20'hFFFF0, 16'h90E9);
    check("R4 bad opcode", boot_bad, 1);
    check("R3 trigger on vector", boot_seen, 1);
  endtask

  task automatic t_warm;
    board_reset(20, 0);
    mem_rd(20'hFFFF0, 16'h5BEA);
    mem_rd(20'hFE05B, 16'h31C0);
    io_wr(20'h00080, 16'h0055);
    check("R5 warm code latched", post_code, 8'h55);
    check("R7 warm no fail", post_fail, 0);
    io_wr(20'h00080, 16'h00FF);
    check("R7 warm no pass", post_pass, 0);
    board_reset(20, 0);
    mem_rd(20'hFFFF0, 16'h5BEA);
    idle(TMO + 50);
    check("R7 warm no timeout", no_post, 0);
  endtask

  task automatic t_retest;
    board_reset(20, 1);
    mem_rd(20'hFFFF0, 16'h5BEA);
    io_wr(20'h00080, 16'h00FF);
    check("R8 retest", retest, 1);
    check("R8 pass suppressed", post_pass, 0);
  endtask

  task automatic t_full;
    board_reset(20, 1);
    mem_rd(20'hFFFF0, 16'h5BEA);
    for (int i = 1; i < 20; i++) mem_rd(20'hF0000 + 20'(i), 16'(16'hA000 + i));
    check("R9 count saturates", rec_count, 16);
    rec_is("R9 last record", 15, 20'hF000F, 16'hA00F);
  endtask

  task automatic t_timeout;
    board_reset(20, 1);
    mem_rd(20'hFFFF0, 16'h5BEA);
    idle(100);
    check("R10 not yet", no_post, 0);
    idle(TMO);
    check("R10 timeout", no_post, 1);
  endtask

  task automatic t_trailing;
    board_reset(20, 1);
    mem_rd(20'hFFFF0, 16'h5BEA);
    @(negedge clk); addr = 20'hFE100; data = 16'h1111; memr_n = 0;
    idle(3); data = 16'h2222; idle(3); memr_n = 1; idle(6);
    rec_is("R11 final value kept", 1, 20'hFE100, 16'h2222);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset_state();
    t_short_reset();
    t_good_boot();
    t_fault_code();
    t_bad_boot();
    t_warm();
    t_retest();
    t_full();
    t_timeout();
    t_trailing();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule